// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller gathers 32 interrupt request lines and presents one interrupt request to the processor. Software keeps a handler address for each source in a per-source vector register. It gives each source a 3-bit priority and unmasks or masks sources with set-style and clear-style command words. When the processor takes the interrupt, it reads the vector register and gets the handler address of the winning source directly. The source number is not returned.

That read is the acknowledge. The priority of the acknowledged source goes onto a hardware nesting stack. From then on, only a source with a strictly higher priority can raise the request line, so a more urgent source can preempt the handler that is running. The handler ends with a write of any value to the end-of-interrupt register. That write pops the stack and restores the level that was in force before. Source 1 is a shared system line: several peripheral request inputs are ORed onto it.

The nesting logic is a two-state machine. IDLE means no interrupt is in service and the stack is empty. NESTED means one or more levels are stacked. The transitions are:
- IDLE→NESTED on an acknowledge.
- NESTED→NESTED on an acknowledge, or on an end-of-interrupt that leaves at least one level.
- NESTED→IDLE on the end-of-interrupt that empties the stack.
- IDLE→IDLE on an end-of-interrupt, which is ignored.

Top module: `vec_intc`

## Requirements
- R1: After reset, every source is masked (the mask register reads 0), `irq` is low, and every vector register reads 0.
- R2: The vector register of source n is a 32-bit read/write register at byte address 0x000 + 4·n.
- R3: A write to the enable command (0x108) unmasks each source whose data bit is 1 (bit n is source n), and leaves sources written with 0 unchanged. The mask register (0x110, read-only) returns the enable state with bit n for source n.
- R4: A write to the disable command (0x10C) masks each source whose data bit is 1 and leaves the others unchanged.
- R5: With the stack empty, `irq` is high exactly when some source is both requesting and unmasked. A masked request never raises `irq`.
- R6: A read of 0x100 returns the vector register of the winning source: the highest priority wins, and equal priorities go to the lowest source number.
- R7: A read of 0x100 that returns a winner pushes that winner's priority. `irq` is low in the following cycle unless a source of strictly higher priority is requesting, and a source of equal or lower priority cannot raise `irq` while that level is stacked.
- R8: A write of any data to 0x104 pops one level and restores the level before it. When the stack becomes empty, any unmasked requesting source raises `irq` again.
- R9: A write to 0x104 while the stack is empty has no effect on the stack or on later nesting.
- R10: Source 1 requests when its own line or any bit of `sys_req` is high.
- R11: A read of 0x100 when no source qualifies returns 0 and does not change the level.
- R12: The priority of source n sits in bits [2:0] of the register at 0x080 + 4·n (0 lowest, 7 highest). Its other bits read as 0.
- R13: The stack holds 8 levels, one for each priority. A full chain of 8 nested acknowledges with priorities 0 to 7 unwinds level by level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of 0x100 acknowledges at the clock edge |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| src_req | input | 32 | Level-sensitive request from each source |
| sys_req | input | 2 | Shared system-line requests, ORed into source 1 |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is a full stack: eight levels deep, with a request of equal priority held back, and the level then restored correctly at each pop. The bench builds this state one level at a time. It gives sources 0 to 7 priorities 0 to 7 and raises each request only after the level below it has been acknowledged. It then pops the stack while the request of the level just retired is still held. At each pop, `irq` must rise while that request is held and fall once it is dropped, because the source one level below has equal priority.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
    localparam int VIC_AW     = 9;
    localparam int VIC_DW     = 32;
    localparam int VIC_SLOT_W = 5;
    localparam int SYS_SRC    = 1;

    localparam logic [VIC_AW-1:0] OFS_IVR  = 9'h100;
    localparam logic [VIC_AW-1:0] OFS_EOI  = 9'h104;
    localparam logic [VIC_AW-1:0] OFS_IEN  = 9'h108;
    localparam logic [VIC_AW-1:0] OFS_IDIS = 9'h10C;
    localparam logic [VIC_AW-1:0] OFS_MASK = 9'h110;

    localparam logic [1:0] BANK_VEC = 2'b00;
    localparam logic [1:0] BANK_PRI = 2'b01;

    typedef enum logic {
        NEST_IDLE,
        NEST_BUSY
    } nest_state_e;
endpackage

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
    import vec_intc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VIC_AW-1:0] bus_addr,
    input  logic [VIC_DW-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              win_ok,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [VIC_DW-1:0] bus_rdata,
    output logic [PRIO_W-1:0] prio_o [NSRC],
    output logic [NSRC-1:0]   mask_o,
    output logic              ack_o,
    output logic              eoi_o
);
    logic [VIC_DW-1:0]     vec_q [NSRC];
    logic [PRIO_W-1:0]     pri_q [NSRC];
    logic [NSRC-1:0]       mask_q;
    logic [VIC_SLOT_W-1:0] slot;
    logic                  aligned, slot_ok;
    logic                  hit_vec, hit_pri, hit_ivr, hit_eoi, hit_ien, hit_dis, hit_mask;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign slot     = bus_addr[VIC_SLOT_W+1:2];
    assign slot_ok  = (32'(slot) < NSRC);
    assign hit_vec  = aligned && slot_ok && (bus_addr[VIC_AW-1:VIC_SLOT_W+2] == BANK_VEC);
    assign hit_pri  = aligned && slot_ok && (bus_addr[VIC_AW-1:VIC_SLOT_W+2] == BANK_PRI);
    assign hit_ivr  = (bus_addr == OFS_IVR);
    assign hit_eoi  = (bus_addr == OFS_EOI);
    assign hit_ien  = (bus_addr == OFS_IEN);
    assign hit_dis  = (bus_addr == OFS_IDIS);
    assign hit_mask = (bus_addr == OFS_MASK);

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vec_q[g] <= '0;
                    pri_q[g] <= '0;
                end else if (bus_wr && 32'(slot) == g) begin
                    if (hit_vec) vec_q[g] <= bus_wdata;
                    if (hit_pri) pri_q[g] <= bus_wdata[PRIO_W-1:0];
                end
            end
            assign prio_o[g] = pri_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (bus_wr && hit_ien) begin
            mask_q <= mask_q | bus_wdata[NSRC-1:0];
        end else if (bus_wr && hit_dis) begin
            mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_vec)       bus_rdata = vec_q[slot[IDX_W-1:0]];
            else if (hit_pri)  bus_rdata = VIC_DW'(pri_q[slot[IDX_W-1:0]]);
            else if (hit_ivr)  bus_rdata = win_ok ? vec_q[win_idx] : '0;
            else if (hit_mask) bus_rdata = VIC_DW'(mask_q);
        end
    end

    assign mask_o = mask_q;
    assign ack_o  = bus_rd && hit_ivr;
    assign eoi_o  = bus_wr && hit_eoi;

    // R3: set-command bits are unmasked one cycle later
    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_ien) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
    // R4: clear-command bits are masked one cycle later
    p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_dis) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));
endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_act,
    input  logic [PRIO_W-1:0] prio [NSRC],
    input  logic              lvl_valid,
    input  logic [PRIO_W-1:0] lvl,
    output logic              win_ok,
    output logic [IDX_W-1:0]  win_idx,
    output logic [PRIO_W-1:0] win_prio
);
    logic found;

    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        // scan from the top so ties settle on the lowest index
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_act[i] && (!found || prio[i] >= win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
        win_ok = found && (!lvl_valid || win_prio > lvl);
    end

    // R6: a qualified winner is always an active request
    p_win_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_ok |-> req_act[win_idx]);
    // R7: a winner never sits at or below the stacked level
    p_win_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ok && lvl_valid) |-> (win_prio > lvl));
endmodule

// File: rtl/vec_intc_nest.sv
module vec_intc_nest
    import vec_intc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_prio,
    output logic              lvl_valid,
    output logic [PRIO_W-1:0] lvl
);
    nest_state_e       state_q, state_d;
    logic [CNT_W-1:0]  depth_q, depth_d;
    logic [PRIO_W-1:0] stk_q [DEPTH];
    logic [PTR_W-1:0]  top_ptr;

    always_comb begin
        state_d = state_q;
        depth_d = depth_q;
        unique case (state_q)
            NEST_IDLE: begin
                if (push) begin
                    state_d = NEST_BUSY;
                    depth_d = CNT_W'(1);
                end
            end
            NEST_BUSY: begin
                if (push) begin
                    if (depth_q < CNT_W'(DEPTH)) depth_d = depth_q + CNT_W'(1);
                end else if (pop) begin
                    depth_d = depth_q - CNT_W'(1);
                    if (depth_q == CNT_W'(1)) state_d = NEST_IDLE;
                end
            end
            default: state_d = NEST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NEST_IDLE;
            depth_q <= '0;
        end else begin
            state_q <= state_d;
            depth_q <= depth_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else if (push && depth_q < CNT_W'(DEPTH)) begin
            stk_q[depth_q[PTR_W-1:0]] <= push_prio;
        end
    end

    always_comb begin
        top_ptr   = PTR_W'(depth_q - CNT_W'(1));
        lvl_valid = (state_q == NEST_BUSY);
        lvl       = lvl_valid ? stk_q[top_ptr] : '0;
    end

    // R13: pushes never arrive with the stack full
    p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (depth_q < CNT_W'(DEPTH)));
    // R9: a pop on an empty stack leaves it empty and idle
    p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && state_q == NEST_IDLE) |=> (depth_q == '0 && state_q == NEST_IDLE));
    // R7: each acknowledge adds exactly one level
    p_push_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (depth_q == CNT_W'($past(depth_q) + CNT_W'(1))));
    // R8: state and depth agree on emptiness
    p_state_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == NEST_IDLE) == (depth_q == '0));
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    parameter int SYS_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VIC_AW-1:0] bus_addr,
    input  logic [VIC_DW-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [VIC_DW-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_req,
    input  logic [SYS_N-1:0]  sys_req,
    output logic              irq
);
    localparam int DEPTH = 2 ** PRIO_W;
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]   eff_req, mask, req_act;
    logic [PRIO_W-1:0] prio [NSRC];
    logic              ack, eoi, push;
    logic              win_ok, lvl_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio, lvl;

    always_comb begin
        eff_req          = src_req;
        eff_req[SYS_SRC] = src_req[SYS_SRC] | (|sys_req);
    end

    assign req_act = eff_req & mask;
    assign push    = ack && win_ok;
    assign irq     = win_ok;

    vec_intc_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .win_ok(win_ok), .win_idx(win_idx),
        .bus_rdata(bus_rdata), .prio_o(prio), .mask_o(mask), .ack_o(ack), .eoi_o(eoi)
    );

    vec_intc_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_act(req_act), .prio(prio),
        .lvl_valid(lvl_valid), .lvl(lvl),
        .win_ok(win_ok), .win_idx(win_idx), .win_prio(win_prio)
    );

    vec_intc_nest #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_nest (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(eoi && !push),
        .push_prio(win_prio), .lvl_valid(lvl_valid), .lvl(lvl)
    );

    // R5: the request line needs an unmasked, requesting source behind it
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(eff_req & mask)));
    // R7: an acknowledge installs the winner's priority as the level
    p_ack_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (lvl_valid && lvl == $past(win_prio)));
endmodule

// File: tb/vec_intc_tb.sv
module vec_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] src_req = '0;
    logic [1:0]  sys_req = '0;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    vec_intc u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .src_req(src_req), .sys_req(sys_req), .irq(irq)
    );

    localparam logic [8:0] A_IVR = 9'h100, A_EOI = 9'h104, A_IEN = 9'h108,
                           A_DIS = 9'h10C, A_MSK = 9'h110;

    function automatic logic [31:0] vexp(input int n);
        return 32'h4000_0000 + 32'(n) * 32'h104;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic irq_is(input bit e, input string tag);
        #1 chk(irq === e, tag, 32'(irq), 32'(e));
    endtask

    task automatic set_req(input int n, input bit v);
        @(negedge clk);
        src_req[n] = v;
    endtask

    task automatic cleanup();
        @(negedge clk);
        src_req = '0; sys_req = '0;
        wr(A_DIS, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_MSK, d); chk(d == 0, "R1 mask", d, 0);
        irq_is(1'b0, "R1 irq");
        rd(9'h014, d); chk(d == 0, "R1 vec5", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        for (int n = 0; n < 32; n++) wr(9'(n * 4), vexp(n));
        for (int n = 0; n < 32; n += 7) begin
            rd(9'(n * 4), d); chk(d == vexp(n), "R2 vector", d, vexp(n));
        end
        rd(9'h07C, d); chk(d == vexp(31), "R2 vector31", d, vexp(31));
        wr(9'h080 + 9'(13 * 4), 32'hFFFF_FFFD);
        rd(9'h080 + 9'(13 * 4), d); chk(d == 32'd5, "R12 prio field", d, 5);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(A_IEN, 32'h0000_00F0);
        wr(A_IEN, 32'h0000_0003);
        rd(A_MSK, d); chk(d == 32'hF3, "R3 enable set", d, 32'hF3);
        wr(A_DIS, 32'h0000_0021);
        rd(A_MSK, d); chk(d == 32'hD2, "R4 disable clr", d, 32'hD2);
        wr(A_DIS, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        set_req(7, 1'b1);
        irq_is(1'b0, "R5 masked");
        wr(A_IEN, 32'h80);
        irq_is(1'b1, "R5 unmasked");
        cleanup();
        irq_is(1'b0, "R5 cleared");
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(9'h080 + 9'(3 * 4), 2);
        wr(9'h080 + 9'(9 * 4), 5);
        wr(9'h080 + 9'(12 * 4), 5);
        wr(9'h080 + 9'(20 * 4), 1);
        wr(A_IEN, (32'd1 << 3) | (32'd1 << 9) | (32'd1 << 12) | (32'd1 << 20));
        @(negedge clk);
        src_req = (32'd1 << 3) | (32'd1 << 9) | (32'd1 << 12) | (32'd1 << 20);
        irq_is(1'b1, "R6 irq");
        rd(A_IVR, d); chk(d == vexp(9), "R6 tie lowest", d, vexp(9));
        irq_is(1'b0, "R7 equal blocked");
        wr(9'h080 + 9'(20 * 4), 6);
        irq_is(1'b1, "R7 higher preempts");
        rd(A_IVR, d); chk(d == vexp(20), "R6 preempt vector", d, vexp(20));
        irq_is(1'b0, "R7 after second ack");
        set_req(20, 1'b0);
        wr(A_EOI, 32'hDEAD_BEEF);
        irq_is(1'b0, "R8 level restored to 5");
        wr(A_EOI, 32'h0);
        irq_is(1'b1, "R8 empty reasserts");
        rd(A_IVR, d); chk(d == vexp(9), "R8 re-ack", d, vexp(9));
        wr(A_EOI, 32'h1234);
        cleanup();
    endtask

    task automatic t_eoi_empty();
        logic [31:0] d;
        wr(A_EOI, 0); wr(A_EOI, 32'hFFFF_FFFF); wr(A_EOI, 5);
        irq_is(1'b0, "R9 no effect irq");
        wr(9'h080 + 9'(4 * 4), 3);
        wr(A_IEN, 32'h10);
        set_req(4, 1'b1);
        irq_is(1'b1, "R9 irq");
        rd(A_IVR, d); chk(d == vexp(4), "R9 vector", d, vexp(4));
        irq_is(1'b0, "R9 level held");
        wr(A_EOI, 0);
        irq_is(1'b1, "R9 single pop empties");
        cleanup();
    endtask

    task automatic t_sys();
        logic [31:0] d;
        wr(A_IEN, 32'h2);
        @(negedge clk) sys_req = 2'b01;
        irq_is(1'b1, "R10 sys bit0");
        rd(A_IVR, d); chk(d == vexp(1), "R10 vector1", d, vexp(1));
        wr(A_EOI, 0);
        @(negedge clk) sys_req = 2'b10;
        irq_is(1'b1, "R10 sys bit1");
        @(negedge clk) sys_req = 2'b00;
        irq_is(1'b0, "R10 sys idle");
        cleanup();
    endtask

    task automatic t_spurious();
        logic [31:0] d;
        rd(A_IVR, d); chk(d == 0, "R11 empty read", d, 0);
        wr(9'h080 + 9'(6 * 4), 0);
        wr(A_IEN, 32'h40);
        set_req(6, 1'b1);
        irq_is(1'b1, "R11 level unchanged");
        cleanup();
    endtask

    task automatic t_nest8();
        logic [31:0] d;
        for (int p = 0; p < 8; p++) wr(9'h080 + 9'(p * 4), 32'(p));
        wr(9'h080 + 9'(8 * 4), 7);
        wr(A_IEN, 32'h1FF);
        for (int p = 0; p < 8; p++) begin
            set_req(p, 1'b1);
            irq_is(1'b1, "R13 push irq");
            rd(A_IVR, d); chk(d == vexp(p), "R13 push vector", d, vexp(p));
            irq_is(1'b0, "R13 push level");
        end
        set_req(8, 1'b1);
        irq_is(1'b0, "R13 full equal blocked");
        set_req(8, 1'b0);
        for (int k = 7; k >= 0; k--) begin
            wr(A_EOI, 32'(k));
            irq_is(1'b1, "R13 pop raises");
            set_req(k, 1'b0);
            irq_is(1'b0, "R13 pop level");
        end
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_mask();
        t_irq();
        t_prio();
        t_eoi_empty();
        t_sys();
        t_spurious();
        t_nest8();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule